// File: doc/BRIEF.md
# Frame-Locked 16-Bit Serial Word Receiver

This block is the receive-only front end of a serial slave port. It is used by a converter-style peripheral that takes commands over a three-wire bus: a select line (active low), a bit clock and a data line. All three lines are asynchronous to the system clock. The block brings them into the system clock domain and detects edges there. While a frame is open, it shifts one data bit in on each falling edge of the bit clock.

A frame opens only when the select line falls. When the sixteenth bit has arrived, the assembled word goes to the downstream decoder with a single-cycle strobe. The receiver then locks itself. Any further bit clocks or data in the same frame have no effect, and the next transfer needs a fresh falling edge on select. If select is released before sixteen bits have arrived, the partial word is thrown away. The output word keeps its last completed value until the next frame completes. There is no return data path, and the meaning of the word is left to downstream logic.

Top module: `spi16_rx`

## Requirements
- R1: After reset, valid_o is 0 and word_o is 0. Bit clock activity while ss_ni stays high produces no strobe and leaves word_o at 0.
- R2: Each falling edge of sclk_i inside an open frame captures mosi_i. Bits arrive MSB first, so the first captured bit lands in word_o[15] and the sixteenth in word_o[0].
- R3: The sixteenth falling sclk_i edge of a frame produces exactly one valid_o pulse, one system clock cycle wide. word_o carries the new word in that same cycle.
- R4: Falling sclk_i edges and mosi_i values that follow the sixteenth edge of a frame are ignored. No second pulse follows, word_o is unchanged, and the shift register does not move.
- R5: If ss_ni rises before sixteen bits have been captured, the partial frame is discarded. No valid_o pulse follows, and word_o keeps its previous value.
- R6: word_o is held stable in every cycle in which valid_o is low.
- R7: A frame opens only on a falling edge of ss_ni. Keeping ss_ni low after a completed frame does not start another one.
- R8: The input lines pass through a two-flop synchronizer. valid_o rises on the third system clock edge after the sixteenth falling sclk_i edge. The system clock must run at least four times faster than sclk_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial bit clock, asynchronous; data is shifted on its falling edge |
| mosi_i | input | 1 | Serial data in, MSB first |
| ss_ni | input | 1 | Frame select, active low; its falling edge opens a frame |
| word_o | output | 16 | Last completed word |
| valid_o | output | 1 | One-cycle strobe marking a new word |

## Verification
Several properties are checked in every cycle by the assertions. The strobe is always a single cycle wide. word_o never moves outside a strobe cycle. The shift register stays frozen while the receiver is locked. A frame can only become open right after a select fall. A select release during an open frame never leads to a strobe.

Other behaviours are shown only by the bench scenarios, because they depend on the serial bit order and on counting edges on the pins. These are the MSB-first bit placement, the strobe arriving exactly on the sixteenth edge, the values of the ignored trailing bits, the latency through the synchronizer, and the rule that holding select low after a frame does not re-arm the receiver.

// File: rtl/spi16_pkg.sv
package spi16_pkg;
  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned LANES      = 3;
  // lane positions inside the synchronizer vector
  localparam int unsigned LANE_SCLK  = 0;
  localparam int unsigned LANE_MOSI  = 1;
  localparam int unsigned LANE_SS    = 2;
endpackage

// File: rtl/spi16_sync.sv
module spi16_sync #(
  parameter int unsigned       W       = 3,
  parameter int unsigned       STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_lane
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[g]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi16_edge.sv
module spi16_edge #(
  parameter int unsigned  W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end
  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/spi16_frame.sv
module spi16_frame #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ss_i,
  input  logic              ss_fall_i,
  input  logic              sclk_fall_i,
  input  logic              mosi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] shift_nxt;

  assign shift_nxt = {shreg_q[WORD_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      word_o   <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (ss_fall_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (active_q && ss_i) begin
        active_q <= 1'b0;            // early release: drop partial word
      end else if (active_q && sclk_fall_i) begin
        shreg_q <= shift_nxt;
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          word_o   <= shift_nxt;
          valid_o  <= 1'b1;
          active_q <= 1'b0;          // lock until next select fall
        end
      end
    end
  end

  p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_locked_shreg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !ss_fall_i) |=> $stable(shreg_q));
  p_discard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && ss_i && !ss_fall_i) |=> !valid_o);
  p_word_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));
  p_open_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(ss_fall_i));
endmodule

// File: rtl/spi16_rx.sv
module spi16_rx
  import spi16_pkg::*;
#(
  parameter int unsigned WORD_W      = WORD_W_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              ss_ni,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  logic [LANES-1:0] raw, synced;
  logic [1:0]       falls;

  assign raw[LANE_SCLK] = sclk_i;
  assign raw[LANE_MOSI] = mosi_i;
  assign raw[LANE_SS]   = ss_ni;

  spi16_sync #(.W(LANES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  // bit 0: bit clock, bit 1: select
  spi16_edge #(.W(2), .RST_VAL(2'b11)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i ({synced[LANE_SS], synced[LANE_SCLK]}),
    .fall_o(falls)
  );

  spi16_frame #(.WORD_W(WORD_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ss_i       (synced[LANE_SS]),
    .ss_fall_i  (falls[1]),
    .sclk_fall_i(falls[0]),
    .mosi_i     (synced[LANE_MOSI]),
    .word_o     (word_o),
    .valid_o    (valid_o)
  );

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (synced[LANE_SS] && !valid_o) |=> !valid_o);
endmodule

// File: tb/spi16_rx_tb_top.sv
module spi16_rx_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b1, mosi = 1'b0, ss_n = 1'b1;
  logic [15:0] word_o;
  logic        valid_o;

  always #4 clk = ~clk;

  spi16_rx dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .mosi_i(mosi),
    .ss_ni(ss_n), .word_o(word_o), .valid_o(valid_o)
  );

  typedef struct packed {
    logic [15:0] data;
    logic [7:0]  nbits;
    logic [7:0]  extra;
    logic        ok;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'hA5C3, 8'd16, 8'd0, 1'b1},
    '{16'hFFFF, 8'd16, 8'd0, 1'b1},
    '{16'h0001, 8'd16, 8'd3, 1'b1},
    '{16'h8000, 8'd16, 8'd0, 1'b1},
    '{16'h1234, 8'd9,  8'd0, 1'b0},
    '{16'h0000, 8'd16, 8'd5, 1'b1},
    '{16'h7E81, 8'd15, 8'd0, 1'b0}
  };

  int errors = 0, checks = 0;
  int cyc = 0, last_fall = 0, pulses = 0, lat = 0;
  logic [15:0] seen_word = '0, exp_word = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (valid_o) begin
      pulses++;
      seen_word = word_o;
      lat = cyc - last_fall;
    end
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic clock_bits(input logic [15:0] d, input int nb, input int ex);
    for (int i = 0; i < nb + ex; i++) begin
      mosi = (i < nb) ? d[15 - (i % 16)] : ~d[15 - (i % 16)];
      wait_n(5);
      sclk = 1'b0;
      last_fall = cyc;
      wait_n(5);
      sclk = 1'b1;
    end
  endtask

  task automatic send(input logic [15:0] d, input int nb, input int ex, input bit keep_low);
    pulses = 0;
    ss_n = 1'b0;
    wait_n(5);
    clock_bits(d, nb, ex);
    wait_n(5);
    if (!keep_low) ss_n = 1'b1;
    wait_n(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(3);
    // R1 reset state
    check(valid_o == 1'b0, "R1 valid after reset", valid_o, 0);
    check(word_o == 16'h0, "R1 word after reset", word_o, 0);
    // R1/R7 bit clocks with select high do nothing
    pulses = 0;
    clock_bits(16'hFFFF, 16, 4);
    wait_n(6);
    check(pulses == 0, "R1 no strobe without select", pulses, 0);
    check(word_o == 16'h0, "R1 word untouched without select", word_o, 0);

    for (int v = 0; v < NV; v++) begin
      send(VECS[v].data, int'(VECS[v].nbits), int'(VECS[v].extra), 1'b0);
      if (VECS[v].ok) exp_word = VECS[v].data;
      if (VECS[v].ok) begin
        check(pulses == 1, "R3 one strobe per frame", pulses, 1);
        check(seen_word == exp_word, "R2 word at strobe", seen_word, exp_word);
        check(lat == 3, "R8 strobe latency", lat, 3);
      end else begin
        check(pulses == 0, "R5 no strobe on partial frame", pulses, 0);
      end
      if (VECS[v].extra != 0)
        check(word_o == exp_word, "R4 trailing bits ignored", word_o, exp_word);
      check(word_o == exp_word, "R6 word held after frame", word_o, exp_word);
    end

    // R7/R4: stay selected after a full frame, keep clocking
    send(16'h3C5A, 16, 0, 1'b1);
    check(pulses == 1, "R3 strobe before hold-low", pulses, 1);
    pulses = 0;
    clock_bits(16'h0F0F, 16, 0);
    wait_n(6);
    check(pulses == 0, "R7 no restart while select held low", pulses, 0);
    check(word_o == 16'h3C5A, "R4 word kept during lockout", word_o, 16'h3C5A);
    ss_n = 1'b1;
    wait_n(6);
    // fresh select fall starts cleanly
    send(16'hC001, 16, 0, 1'b0);
    check(pulses == 1 && word_o == 16'hC001, "R7 new frame after reselect", word_o, 16'hC001);
    check(word_o[15] == 1'b1 && word_o[0] == 1'b1, "R2 MSB first placement", word_o, 16'hC001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule